// File: doc/BRIEF.md
# Token-Chain Serial Bus Node

This block is one node on a shared two-wire serial bus. All nodes share a serial clock line and an open-drain data line. A separate chain line runs from node to node and decides which node may take the bus. A node may start a message only while its chain input is high and the bus is idle. It starts by pulling the data line low. Any node whose clock generator is enabled sees that and begins to toggle the shared clock.

A message is an 8-bit address and then an 8-bit data byte, both sent most significant bit first. One acknowledge slot follows. The sending node changes the data line after each falling clock edge, and every node samples it on the rising edge. The clock runs for one start pulse, one pulse per bit and one acknowledge pulse, and then stops. Afterwards the bus is idle again: data released high and clock low.

A non-sending node whose configured address matches the received address presents the data byte. It then pulls the data line low during the acknowledge slot. The sender stores the outcome of that slot in a status bit. A node that wants the bus holds its chain output low so that nodes further down the chain wait. A node that does not want the bus copies its chain input to its chain output.

Top module: `tcbus_node`

## Requirements
- R1: After reset the node releases the data line (sda_pull_o = 0), holds sclk_o low, and keeps tx_busy_o, tx_acked_o, tx_done_o and rx_valid_o at 0.
- R2: While the node has no request pending or in progress, chain_o equals chain_i.
- R3: A pending request starts a message only when chain_i is high and the bus is idle. The node starts it by pulling the data line low. While chain_i is low the request waits and the data line stays released.
- R4: From accepting a request until the end of its own message, the node drives chain_o low.
- R5: When clkgen_en_i is high and a start has been seen, the node drives exactly 18 rising edges on sclk_o, each half period HALF_CYC clocks long, and then holds sclk_o low. With clkgen_en_i low, sclk_o stays low and a started message waits, with the data line held low, until a generator is enabled.
- R6: On the bus, the first rising edge is a start pulse with data low. Rising edges 2 to 17 carry the address and then the data, each MSB first. Rising edge 18 is the acknowledge slot.
- R7: A node that is not the sender, and whose own_addr_i equals the received address, pulses rx_valid_o for one clock with rx_data_o set to the data byte. It then drives data low in the acknowledge slot. Any other node receives nothing and does not acknowledge.
- R8: At the end of its message the sender pulses tx_done_o for one clock. It sets tx_acked_o to 1 if the data line was low at the acknowledge edge, and to 0 if it was high.
- R9: After the acknowledge slot every node releases the data line and the clock stops, so the bus is idle and a new message can start.
- R10: A tx_req_i that arrives while tx_busy_o is high is ignored. Only the first request's address and data are sent.
- R11: When two nodes on the chain request in the same cycle while the upstream node holds the token, the upstream node sends first and the downstream node sends after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Node clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clkgen_en_i | input | 1 | Enables this node's bus clock generator |
| own_addr_i | input | ADDR_W | Address this node answers to |
| chain_i | input | 1 | Token from the previous node |
| chain_o | output | 1 | Token to the next node |
| sclk_i | input | 1 | Shared serial clock as seen on the bus |
| sclk_o | output | 1 | Serial clock from this node's generator |
| sda_i | input | 1 | Shared data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls the shared data line low |
| tx_req_i | input | 1 | One-cycle send request |
| tx_addr_i | input | ADDR_W | Destination address for the request |
| tx_data_i | input | DATA_W | Data byte for the request |
| tx_busy_o | output | 1 | Request pending or message in progress |
| tx_done_o | output | 1 | One-cycle pulse at the end of the node's own message |
| tx_acked_o | output | 1 | Acknowledge result of the last message sent |
| rx_valid_o | output | 1 | One-cycle pulse when a message to this node has been received |
| rx_data_o | output | DATA_W | Data byte received |

## Verification
The case that matters is two nodes asking for the bus in the same cycle. The token grant and the bus-idle check then fall on the same clock edge in both nodes. The bench issues requests to two chained nodes on a single falling clock edge while the upstream node holds the token. The downstream node must see its chain input drop before it can claim the bus. The bench judges the result by the order of the tx_done_o pulses, by the data each receiver presents, and by checking that the bus capture shows two clean frames and no merged frame.

// File: rtl/tcbus_pkg.sv
package tcbus_pkg;

  typedef enum logic [1:0] {
    GEN_IDLE = 2'd0,
    GEN_LOW  = 2'd1,
    GEN_HIGH = 2'd2
  } gen_st_e;

  // start pulse + address/data bits + acknowledge pulse
  function automatic int frame_rises(input int addr_w, input int data_w);
    return addr_w + data_w + 2;
  endfunction

endpackage

// File: rtl/tcbus_sync.sv
module tcbus_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] prev_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {(STAGES+1){RST_VAL[g]}};
      else         ff_q <= {ff_q[STAGES-1:0], din_i[g]};
    end
    assign dout_o[g] = ff_q[STAGES-1];
    assign prev_o[g] = ff_q[STAGES];
  end

endmodule

// File: rtl/tcbus_clkgen.sv
module tcbus_clkgen
  import tcbus_pkg::*;
#(
  parameter int HALF_CYC = 8,
  parameter int N_RISE   = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  output logic sclk_o,
  output logic run_o
);

  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int NW = $clog2(N_RISE + 1);
  localparam logic [TW-1:0] T_LAST = TW'(HALF_CYC - 1);
  localparam logic [NW-1:0] N_LAST = NW'(N_RISE);

  gen_st_e        st_q;
  logic [TW-1:0]  tmr_q;
  logic [NW-1:0]  nr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= GEN_IDLE;
      tmr_q <= '0;
      nr_q  <= '0;
    end else begin
      unique case (st_q)
        GEN_IDLE: begin
          if (en_i && start_i) begin
            st_q  <= GEN_LOW;
            tmr_q <= '0;
            nr_q  <= '0;
          end
        end
        GEN_LOW: begin
          if (tmr_q != T_LAST) tmr_q <= tmr_q + 1'b1;
          else begin
            tmr_q <= '0;
            if (nr_q == N_LAST) st_q <= GEN_IDLE;   // trailing low half done
            else begin
              st_q <= GEN_HIGH;
              nr_q <= nr_q + 1'b1;
            end
          end
        end
        GEN_HIGH: begin
          if (tmr_q != T_LAST) tmr_q <= tmr_q + 1'b1;
          else begin
            tmr_q <= '0;
            st_q  <= GEN_LOW;
          end
        end
        default: st_q <= GEN_IDLE;
      endcase
    end
  end

  assign sclk_o = (st_q == GEN_HIGH);
  assign run_o  = (st_q != GEN_IDLE);

endmodule

// File: rtl/tcbus_frame.sv
module tcbus_frame #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sda_i,
  input  logic              sda_fall_i,
  input  logic              chain_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              tx_req_i,
  input  logic [ADDR_W-1:0] tx_addr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              pend_o,
  output logic              master_o,
  output logic              bus_act_o,
  output logic              at_start_o,
  output logic              sda_pull_o,
  output logic              tx_done_o,
  output logic              tx_acked_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);

  localparam int FB = ADDR_W + DATA_W;
  localparam int RW = $clog2(FB + 3);
  localparam logic [RW-1:0] R_LAST = RW'(FB);
  localparam logic [RW-1:0] R_ACK  = RW'(FB + 1);
  localparam logic [RW-1:0] R_END  = RW'(FB + 2);

  logic              pend_q, master_q, bus_act_q, ack_pend_q, pull_q;
  logic              done_q, acked_q, rxv_q;
  logic [RW-1:0]     rcnt_q;
  logic [FB-1:0]     tx_sh_q, rx_sh_q;
  logic [DATA_W-1:0] rxd_q;
  logic [FB-1:0]     rx_nxt;
  logic              claim, in_bits, addr_hit;

  assign rx_nxt   = {rx_sh_q[FB-2:0], sda_i};
  assign in_bits  = (rcnt_q != '0) && (rcnt_q <= R_LAST);
  assign addr_hit = (rx_nxt[FB-1 -: ADDR_W] == own_addr_i);
  assign claim    = pend_q && !master_q && !bus_act_q && chain_i && sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      master_q   <= 1'b0;
      bus_act_q  <= 1'b0;
      ack_pend_q <= 1'b0;
      pull_q     <= 1'b0;
      done_q     <= 1'b0;
      acked_q    <= 1'b0;
      rxv_q      <= 1'b0;
      rcnt_q     <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      rxd_q      <= '0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      if (tx_req_i && !pend_q && !master_q) begin
        pend_q  <= 1'b1;
        tx_sh_q <= {tx_addr_i, tx_data_i};
      end
      if (claim) begin
        pend_q   <= 1'b0;
        master_q <= 1'b1;
        pull_q   <= 1'b1;           // start condition
      end
      if (!bus_act_q) begin
        if (sda_fall_i) begin
          bus_act_q  <= 1'b1;
          rcnt_q     <= '0;
          ack_pend_q <= 1'b0;
        end
      end else if (sclk_rise_i) begin
        rcnt_q <= rcnt_q + 1'b1;
        if (in_bits) rx_sh_q <= rx_nxt;
        if (rcnt_q == R_LAST && !master_q && addr_hit) begin
          rxv_q      <= 1'b1;
          rxd_q      <= rx_nxt[DATA_W-1:0];
          ack_pend_q <= 1'b1;
        end
        if (rcnt_q == R_ACK && master_q) acked_q <= ~sda_i;
      end else if (sclk_fall_i) begin
        if (master_q && in_bits) begin
          pull_q  <= ~tx_sh_q[FB-1];
          tx_sh_q <= {tx_sh_q[FB-2:0], 1'b0};
        end else if (rcnt_q == R_ACK) begin
          pull_q <= ack_pend_q & ~master_q;
        end else if (rcnt_q == R_END) begin
          pull_q     <= 1'b0;
          ack_pend_q <= 1'b0;
          bus_act_q  <= 1'b0;
          if (master_q) begin
            master_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign pend_o     = pend_q;
  assign master_o   = master_q;
  assign bus_act_o  = bus_act_q;
  assign at_start_o = bus_act_q && (rcnt_q == '0);
  assign sda_pull_o = pull_q;
  assign tx_done_o  = done_q;
  assign tx_acked_o = acked_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;

endmodule

// File: rtl/tcbus_node.sv
module tcbus_node
  import tcbus_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int HALF_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clkgen_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              chain_i,
  output logic              chain_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              tx_req_i,
  input  logic [ADDR_W-1:0] tx_addr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_busy_o,
  output logic              tx_done_o,
  output logic              tx_acked_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);

  localparam int N_RISE = frame_rises(ADDR_W, DATA_W);

  logic [1:0] line_s, line_p;
  logic       sclk_s_w, sda_s_w;
  logic       sclk_rise, sclk_fall, sda_fall;
  logic       pend_w, master_w, bus_act_w, at_start_w, gen_run_w;

  // bit 1: data (idles high), bit 0: clock (idles low)
  tcbus_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  ({sda_i, sclk_i}),
    .dout_o (line_s),
    .prev_o (line_p)
  );

  assign sclk_s_w  = line_s[0];
  assign sda_s_w   = line_s[1];
  assign sclk_rise = line_s[0] & ~line_p[0];
  assign sclk_fall = ~line_s[0] & line_p[0];
  assign sda_fall  = ~line_s[1] & line_p[1];

  tcbus_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sda_i       (sda_s_w),
    .sda_fall_i  (sda_fall),
    .chain_i     (chain_i),
    .own_addr_i  (own_addr_i),
    .tx_req_i    (tx_req_i),
    .tx_addr_i   (tx_addr_i),
    .tx_data_i   (tx_data_i),
    .pend_o      (pend_w),
    .master_o    (master_w),
    .bus_act_o   (bus_act_w),
    .at_start_o  (at_start_w),
    .sda_pull_o  (sda_pull_o),
    .tx_done_o   (tx_done_o),
    .tx_acked_o  (tx_acked_o),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o)
  );

  tcbus_clkgen #(.HALF_CYC(HALF_CYC), .N_RISE(N_RISE)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clkgen_en_i),
    .start_i (at_start_w),
    .sclk_o  (sclk_o),
    .run_o   (gen_run_w)
  );

  // a node wanting the bus keeps the token from downstream nodes
  assign tx_busy_o = pend_w | master_w;
  assign chain_o   = chain_i & ~tx_busy_o;

endmodule

// File: rtl/tcbus_node_chk.sv
module tcbus_node_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clkgen_en_i,
  input logic chain_i,
  input logic chain_o,
  input logic sclk_o,
  input logic sda_pull_o,
  input logic tx_done_o,
  input logic rx_valid_o,
  input logic master,
  input logic bus_act,
  input logic gen_run,
  input logic sclk_s
);

  a_r3_start_needs_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master) |-> ($past(chain_i) && !$past(bus_act)));

  a_r4_start_holds_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o && !bus_act) |-> !chain_o);

  a_r5_clk_low_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_run |-> !sclk_o);

  a_r5_gen_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gen_run) |-> $past(clkgen_en_i));

  a_r6_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_s && $past(sclk_s)) |-> $stable(sda_pull_o));

  a_r7_no_self_receive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !master);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);

endmodule

bind tcbus_node tcbus_node_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clkgen_en_i (clkgen_en_i),
  .chain_i     (chain_i),
  .chain_o     (chain_o),
  .sclk_o      (sclk_o),
  .sda_pull_o  (sda_pull_o),
  .tx_done_o   (tx_done_o),
  .rx_valid_o  (rx_valid_o),
  .master      (master_w),
  .bus_act     (bus_act_w),
  .gen_run     (gen_run_w),
  .sclk_s      (sclk_s_w)
);

// File: tb/tcbus_node_bench.sv
module tcbus_node_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       tok, gen_a, gen_b;
  logic       a_req, b_req;
  logic [7:0] a_ta, a_td, b_ta, b_td;
  logic       a_chain, b_chain, a_sclk, b_sclk, a_pull, b_pull;
  logic       a_busy, b_busy, a_done, b_done, a_ack, b_ack, a_rxv, b_rxv;
  logic [7:0] a_rxd, b_rxd;
  logic       sclk, sda;

  assign sclk = a_sclk | b_sclk;
  assign sda  = ~(a_pull | b_pull);   // weak pull-up, open-drain pulls

  tcbus_node u_tcbus_node (
    .clk_i(clk), .rst_ni(rst_n), .clkgen_en_i(gen_a), .own_addr_i(8'h3C),
    .chain_i(tok), .chain_o(a_chain), .sclk_i(sclk), .sclk_o(a_sclk),
    .sda_i(sda), .sda_pull_o(a_pull), .tx_req_i(a_req), .tx_addr_i(a_ta),
    .tx_data_i(a_td), .tx_busy_o(a_busy), .tx_done_o(a_done),
    .tx_acked_o(a_ack), .rx_valid_o(a_rxv), .rx_data_o(a_rxd));

  tcbus_node u_tcbus_node_b (
    .clk_i(clk), .rst_ni(rst_n), .clkgen_en_i(gen_b), .own_addr_i(8'h5A),
    .chain_i(a_chain), .chain_o(b_chain), .sclk_i(sclk), .sclk_o(b_sclk),
    .sda_i(sda), .sda_pull_o(b_pull), .tx_req_i(b_req), .tx_addr_i(b_ta),
    .tx_data_i(b_td), .tx_busy_o(b_busy), .tx_done_o(b_done),
    .tx_acked_o(b_ack), .rx_valid_o(b_rxv), .rx_data_o(b_rxd));

  // bus and port monitor, sampled mid-cycle
  int          n_chk = 0, n_fail = 0, cyc = 0;
  int          rises = 0, a_rx_n = 0, b_rx_n = 0, a_dn = 0, b_dn = 0;
  int          a_dt = 0, b_dt = 0;
  logic [17:0] cap = '0;
  logic [7:0]  a_rx_last = '0, b_rx_last = '0;
  logic        sclk_prev = 1'b0, b_sclk_seen = 1'b0;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sclk_prev <= sclk;
    if (sclk && !sclk_prev) begin
      cap   <= {cap[16:0], sda};
      rises <= rises + 1;
    end
    if (a_rxv) begin a_rx_n <= a_rx_n + 1; a_rx_last <= a_rxd; end
    if (b_rxv) begin b_rx_n <= b_rx_n + 1; b_rx_last <= b_rxd; end
    if (a_done) begin a_dn <= a_dn + 1; a_dt <= cyc; end
    if (b_done) begin b_dn <= b_dn + 1; b_dt <= cyc; end
    if (b_sclk) b_sclk_seen <= 1'b1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: act=hung exp=finished");
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic req(input bit on_b, input logic [7:0] ad, input logic [7:0] dt);
    @(negedge clk);
    if (on_b) begin b_ta = ad; b_td = dt; b_req = 1'b1; end
    else      begin a_ta = ad; a_td = dt; a_req = 1'b1; end
    @(negedge clk);
    a_req = 1'b0;
    b_req = 1'b0;
  endtask

  task automatic wait_done(input bit on_b, input string tag);
    int base;
    bit seen;
    base = on_b ? b_dn : a_dn;
    seen = 1'b0;
    for (int i = 0; i < WAIT_MAX && !seen; i++) begin
      @(negedge clk);
      seen = ((on_b ? b_dn : a_dn) != base);
    end
    chk(seen, tag, 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sda == 1'b1 && !a_pull && !b_pull, "R1 data released", sda, 1);
    chk(sclk == 1'b0, "R1 clock low", sclk, 0);
    chk(!a_busy && !a_ack && !a_done && !a_rxv, "R1 status clear",
        {a_busy, a_ack, a_done, a_rxv}, 0);
    chk(a_chain == tok && b_chain == tok, "R2 token passed", {a_chain, b_chain}, {tok, tok});
  endtask

  task automatic t_basic();
    int r0, n0;
    bit started;
    r0 = rises; n0 = b_rx_n;
    req(1'b0, 8'h5A, 8'hA5);
    started = 1'b0;
    for (int i = 0; i < 100 && !started; i++) begin
      @(negedge clk);
      started = (sda == 1'b0);
    end
    idle(20);
    chk(a_chain == 1'b0 && b_chain == 1'b0, "R4 chain low in message", {a_chain, b_chain}, 0);
    wait_done(1'b0, "R8 done pulse A->B");
    chk(a_ack == 1'b1, "R8 acked by matching node", a_ack, 1);
    idle(40);
    chk(rises - r0 == 18, "R5 eighteen rising edges", rises - r0, 18);
    chk(cap == {1'b0, 8'h5A, 8'hA5, 1'b0}, "R6 frame MSB first", cap, {1'b0, 16'h5AA5, 1'b0});
    chk(b_rx_n - n0 == 1 && b_rx_last == 8'hA5, "R7 receiver data", b_rx_last, 8'hA5);
    chk(sda == 1'b1 && sclk == 1'b0, "R9 bus idle after ack", {sda, sclk}, 2'b10);
    chk(a_chain == 1'b1, "R4 chain restored", a_chain, 1);
  endtask

  task automatic t_nomatch();
    int r0, n0;
    r0 = rises; n0 = b_rx_n;
    req(1'b0, 8'h77, 8'h3C);
    wait_done(1'b0, "R8 done unmatched");
    idle(40);
    chk(a_ack == 1'b0, "R8 no ack recorded", a_ack, 0);
    chk(b_rx_n == n0, "R7 no receive on mismatch", b_rx_n - n0, 0);
    chk(cap == {1'b0, 8'h77, 8'h3C, 1'b1} && rises - r0 == 18, "R6 unacked frame",
        cap, {1'b0, 16'h773C, 1'b1});
  endtask

  task automatic t_b_to_a();
    int n0;
    n0 = a_rx_n;
    req(1'b1, 8'h3C, 8'h96);
    wait_done(1'b1, "R8 done B->A");
    idle(40);
    chk(b_ack == 1'b1, "R8 B acked", b_ack, 1);
    chk(a_rx_n - n0 == 1 && a_rx_last == 8'h96, "R7 A receives", a_rx_last, 8'h96);
  endtask

  task automatic t_token();
    int r0, n0;
    bit quiet;
    r0 = rises; n0 = a_rx_n;
    tok = 1'b0;
    idle(2);
    chk(a_chain == 1'b0, "R2 idle node passes low token", a_chain, 0);
    req(1'b1, 8'h3C, 8'h42);
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sda != 1'b1) quiet = 1'b0;
    end
    chk(quiet && rises == r0, "R3 waits without token", rises - r0, 0);
    chk(b_busy == 1'b1, "R3 request held pending", b_busy, 1);
    tok = 1'b1;
    wait_done(1'b1, "R3 starts once token arrives");
    idle(40);
    chk(a_rx_n - n0 == 1 && a_rx_last == 8'h42, "R3 late message delivered", a_rx_last, 8'h42);
  endtask

  task automatic t_both();
    int a0, b0, na, nb;
    bit fin;
    a0 = a_dn; b0 = b_dn; na = b_rx_n; nb = a_rx_n;
    @(negedge clk);
    a_ta = 8'h5A; a_td = 8'h01; a_req = 1'b1;
    b_ta = 8'h3C; b_td = 8'h02; b_req = 1'b1;
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
    fin = 1'b0;
    for (int i = 0; i < 2 * WAIT_MAX && !fin; i++) begin
      @(negedge clk);
      fin = (a_dn != a0) && (b_dn != b0);
    end
    chk(fin, "R11 both messages finish", {a_dn - a0, b_dn - b0}, 2'b11);
    chk(a_dt < b_dt, "R11 upstream sends first", a_dt, b_dt);
    idle(40);
    chk(b_rx_n - na == 1 && b_rx_last == 8'h01, "R11 first frame intact", b_rx_last, 8'h01);
    chk(a_rx_n - nb == 1 && a_rx_last == 8'h02, "R11 second frame intact", a_rx_last, 8'h02);
    chk(cap == {1'b0, 8'h3C, 8'h02, 1'b0}, "R11 last frame clean", cap, {1'b0, 16'h3C02, 1'b0});
  endtask

  task automatic t_busy_ignore();
    int r0, n0;
    r0 = rises; n0 = b_rx_n;
    req(1'b0, 8'h5A, 8'h11);
    idle(3);
    req(1'b0, 8'h5A, 8'h22);
    wait_done(1'b0, "R10 first request done");
    idle(500);
    chk(b_rx_n - n0 == 1 && b_rx_last == 8'h11, "R10 second request ignored", b_rx_last, 8'h11);
    chk(rises - r0 == 18 && !a_busy, "R10 only one frame", rises - r0, 18);
  endtask

  task automatic t_gen_off();
    int r0, n0;
    r0 = rises; n0 = b_rx_n;
    gen_a = 1'b0;
    req(1'b0, 8'h5A, 8'h77);
    idle(300);
    chk(sda == 1'b0 && rises == r0, "R5 no clock while disabled", rises - r0, 0);
    chk(a_busy == 1'b1, "R5 message waits", a_busy, 1);
    gen_a = 1'b1;
    wait_done(1'b0, "R5 resumes when enabled");
    idle(40);
    chk(b_rx_n - n0 == 1 && b_rx_last == 8'h77 && a_ack, "R5 late frame delivered", b_rx_last, 8'h77);
    chk(!b_sclk_seen, "R5 disabled generator silent", b_sclk_seen, 0);
  endtask

  initial begin
    tok = 1'b1; gen_a = 1'b1; gen_b = 1'b0;
    a_req = 1'b0; b_req = 1'b0;
    a_ta = '0; a_td = '0; b_ta = '0; b_td = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_basic();
    t_nomatch();
    t_b_to_a();
    t_token();
    t_both();
    t_busy_ignore();
    t_gen_off();
    report();
    $finish;
  end

endmodule